// File: doc/BRIEF.md
# Operand-Swapping Radix-4 Booth Multiplier

This block multiplies two signed 16-bit two's complement operands and returns the exact 32-bit signed product. It uses radix-4 Booth recoding. One operand is recoded into eight signed digits. The other operand, the multiplicand, is scaled by each digit to form one partial product. A column-wise carry-save tree reduces the partial products, and a single carry-propagate adder finishes the sum.

A steering input, sent with each operand pair, decides which operand is recoded. The source that drives the block knows which operand has the narrower value range, and it raises the steering bit when that operand is the first one. The narrower operand then feeds the recoder. More of its digits are zero, so fewer partial-product bits toggle. The steering bit changes only which operand is recoded. The product does not depend on it.

Operands enter through a valid/ready handshake, and products leave through a second one. A pair is taken on any clock edge where `in_valid` and `in_ready` are both high. A product is handed over on any edge where `out_valid` and `out_ready` are both high. When the consumer holds `out_ready` low while a product is waiting, the whole pipeline freezes and `in_ready` drops. This holds all three register stages, the output included. While the pipeline is frozen, the producer must keep its pair stable until `in_ready` returns.

Top module: `booth_mul`

## Requirements
- R1: For every accepted pair, `out_prod` equals the exact signed product `in_a * in_b`, taken as 32-bit two's complement. This includes -32768 x -32768 = 0x40000000, 32767 x -32768 = 0xC0008000, -1 x -1 = 1, and any product with a zero operand, which is 0.
- R2: When `in_swap` = 0, `in_b` is recoded and `in_a` is the multiplicand. When `in_swap` = 1, `in_a` is recoded and `in_b` is the multiplicand. The same operand pair gives the same product with either setting.
- R3: The recoder uses radix 4. Digit i (i = 0..7) is formed from bits 2i+1, 2i and 2i-1 of the recoded operand, where bit -1 is 0. It takes a value in {-2, -1, 0, +1, +2}. Operands built from alternating bit patterns, and operands at the extremes of the range, must still give exact products.
- R4: Suppose a pair is accepted on clock edge k and the pipeline is not frozen on the next two edges. Its product is then presented, with `out_valid` high, from edge k+2.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` keeps its value on the next edge. `out_valid` falls only after an edge on which `out_ready` was high.
- R6: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A pair is taken only on an edge where `in_valid` and `in_ready` are both high.
- R7: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is low and `in_ready` is high.
- R8: Cycles with `in_valid` low produce no product. Products come out in the order their pairs were accepted, one product per accepted pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair on this edge |
| in_a | input | 16 | First signed operand |
| in_b | input | 16 | Second signed operand |
| in_swap | input | 1 | 1: recode `in_a`; 0: recode `in_b` |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product on this edge |
| out_prod | output | 32 | Signed product |

## Verification
A product is due two edges after its pair is accepted, plus one edge for each cycle in that interval on which the pipeline was frozen. The bench samples on the falling edge. It counts those frozen cycles, and the reference model records the accept cycle of every pair in flight. On each clock it derives the exact cycle at which `out_valid` must be high, and it compares both `out_valid` and the value of the head product on that cycle. On every cycle it also checks the hold rule for a waiting product and the rule that gives `in_ready`.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;

  function automatic int csa_next(int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int csa_rows(int n0, int lvl);
    int n;
    n = n0;
    for (int i = 0; i < lvl; i++) n = csa_next(n);
    return n;
  endfunction

  function automatic int csa_depth(int n0);
    int n;
    int d;
    n = n0;
    d = 0;
    while (n > 2) begin
      n = csa_next(n);
      d++;
    end
    return d;
  endfunction

  function automatic int csa_base(int n0, int lvl);
    int s;
    s = 0;
    for (int i = 0; i < lvl; i++) s += csa_rows(n0, i);
    return s;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
#(
  parameter int W = 16,
  localparam int ND = W / 2
) (
  input  logic [W-1:0]              mplier,
  output booth_digit_t [ND-1:0]     digits
);

  logic [W:0] ext;
  assign ext = {mplier, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [2:0] grp;
    assign grp = ext[2*i+2 -: 3];
    assign digits[i].neg = grp[2] & ~(grp[1] & grp[0]);
    assign digits[i].one = grp[1] ^ grp[0];
    assign digits[i].two = (grp[2] & ~grp[1] & ~grp[0]) |
                           (~grp[2] & grp[1] & grp[0]);
  end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_mul_pkg::*;
#(
  parameter int W   = 16,
  parameter int IDX = 0,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  mcand,
  input  booth_digit_t  digit,
  output logic [PW-1:0] row
);

  logic [W:0]    sel;
  logic [W:0]    flip;
  logic [PW-1:0] wide;

  always_comb begin
    if (digit.two)      sel = {mcand, 1'b0};
    else if (digit.one) sel = {mcand[W-1], mcand};
    else                sel = '0;
  end

  assign flip = sel ^ {(W+1){digit.neg}};
  assign wide = {{(PW-W-1){flip[W]}}, flip};
  assign row  = wide << (2 * IDX);

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import booth_mul_pkg::*;
#(
  parameter int PW   = 32,
  parameter int ROWS = 9,
  localparam int DEPTH = csa_depth(ROWS),
  localparam int TOTAL = csa_base(ROWS, DEPTH + 1)
) (
  input  logic [ROWS-1:0][PW-1:0] rows,
  output logic [PW-1:0]           sum
);

  logic [PW-1:0] node [0:TOTAL-1];

  for (genvar r = 0; r < ROWS; r++) begin : g_in
    assign node[r] = rows[r];
  end

  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int NIN  = csa_rows(ROWS, l);
    localparam int BIN  = csa_base(ROWS, l);
    localparam int BOUT = csa_base(ROWS, l + 1);
    localparam int NG   = NIN / 3;
    localparam int NR   = NIN % 3;
    for (genvar g = 0; g < NG; g++) begin : g_csa
      logic [PW-1:0] x, y, z;
      assign x = node[BIN + 3*g];
      assign y = node[BIN + 3*g + 1];
      assign z = node[BIN + 3*g + 2];
      assign node[BOUT + 2*g]     = x ^ y ^ z;
      assign node[BOUT + 2*g + 1] = ((x & y) | (x & z) | (y & z)) << 1;
    end
    for (genvar p = 0; p < NR; p++) begin : g_pass
      assign node[BOUT + 2*NG + p] = node[BIN + 3*NG + p];
    end
  end

  localparam int BLAST = csa_base(ROWS, DEPTH);
  assign sum = node[BLAST] + node[BLAST + 1];

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int W = 16,
  localparam int ND = W / 2,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic          in_swap,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_prod
);

  logic          adv;
  logic          v1_q, v2_q, v3_q;
  logic [W-1:0]  a1_q, b1_q;
  logic          sw1_q;
  logic [W-1:0]  mcand_q, mplier_q;
  logic [PW-1:0] prod_q;

  assign adv      = !v3_q || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      a1_q  <= '0;
      b1_q  <= '0;
      sw1_q <= 1'b0;
    end else if (adv) begin
      v1_q <= in_valid;
      if (in_valid) begin
        a1_q  <= in_a;
        b1_q  <= in_b;
        sw1_q <= in_swap;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2_q     <= 1'b0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (adv) begin
      v2_q <= v1_q;
      if (v1_q) begin
        mcand_q  <= sw1_q ? b1_q : a1_q;
        mplier_q <= sw1_q ? a1_q : b1_q;
      end
    end
  end

  booth_digit_t [ND-1:0]   digits;
  logic [ND:0][PW-1:0]     rows;
  logic [PW-1:0]           corr;
  logic [PW-1:0]           sum;

  booth_recoder #(.W(W)) i_rec (
    .mplier (mplier_q),
    .digits (digits)
  );

  for (genvar i = 0; i < ND; i++) begin : g_pp
    booth_pp_row #(.W(W), .IDX(i)) i_pp (
      .mcand (mcand_q),
      .digit (digits[i]),
      .row   (rows[i])
    );
  end

  always_comb begin
    corr = '0;
    for (int i = 0; i < ND; i++) corr[2*i] = digits[i].neg;
  end
  assign rows[ND] = corr;

  csa_tree #(.PW(PW), .ROWS(ND + 1)) i_tree (
    .rows (rows),
    .sum  (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3_q   <= 1'b0;
      prod_q <= '0;
    end else if (adv) begin
      v3_q <= v2_q;
      if (v2_q) prod_q <= sum;
    end
  end

  assign out_valid = v3_q;
  assign out_prod  = prod_q;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_prod
);

  // R4: accepted pair with two free edges after it is presented
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready |=> out_valid);

  // R5: waiting product is held
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R5: valid drops only after a transfer
  a_r5_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R6: empty output stage always accepts
  a_r6_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: state right after reset release
  a_r7_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

endmodule

bind booth_mul booth_mul_chk #(.PW(PW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/test_booth_mul.sv
`timescale 1ns/1ps
module test_booth_mul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        in_swap = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_prod;

  always #10 clk = ~clk;

  booth_mul i_booth_mul (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_a (in_a), .in_b (in_b), .in_swap (in_swap),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_prod (out_prod)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall_cnt = 0;
  int stall_pct = 0;
  bit done = 0;
  bit running = 0;

  int          q_cyc [$];
  int          q_stl [$];
  logic [31:0] q_exp [$];
  string       q_tag [$];

  logic        prev_hold = 0;
  logic [31:0] prev_prod = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // per-clock reference comparison
  always @(negedge clk) begin
    if (running) begin
      bit exp_v;
      exp_v = 0;
      if (q_exp.size() > 0)
        exp_v = ((cyc - q_cyc[0] - 3) == (stall_cnt - q_stl[0]));
      chk(out_valid == exp_v, "R4/R8 out_valid timing", 32'(out_valid), 32'(exp_v));
      chk(in_ready == (!out_valid || out_ready), "R6 in_ready rule",
          32'(in_ready), 32'(!out_valid || out_ready));
      if (prev_hold)
        chk(out_valid && out_prod == prev_prod, "R5 hold while stalled",
            out_prod, prev_prod);
      if (out_valid && exp_v)
        chk(out_prod == q_exp[0], q_tag[0], out_prod, q_exp[0]);
      if (out_valid && out_ready && q_exp.size() > 0) begin
        void'(q_cyc.pop_front());
        void'(q_stl.pop_front());
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end
      prev_hold = out_valid && !out_ready;
      prev_prod = out_prod;
      if (!in_ready) stall_cnt++;
      if (in_valid && in_ready) begin
        q_cyc.push_back(cyc);
        q_stl.push_back(stall_cnt);
        q_exp.push_back(32'(int'($signed(in_a)) * int'($signed(in_b))));
        q_tag.push_back(in_swap ? "R1/R2/R3 product swap=1" : "R1/R2/R3 product swap=0");
      end
    end
  end

  // consumer side
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (stall_pct == 0) out_ready = 1'b1;
      else out_ready = (($urandom % 100) >= stall_pct);
    end
  end

  task automatic send(logic [15:0] a, logic [15:0] b, logic sw);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    in_swap = sw;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
  endtask

  task automatic idle(int n);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_a = 16'hDEAD;
    in_b = 16'hBEEF;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic both(logic [15:0] a, logic [15:0] b);
    send(a, b, 1'b0);
    send(a, b, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid in reset", 32'(out_valid), 32'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R7 in_ready after reset", 32'(in_ready), 32'd1);
    running = 1;

    // directed corners, back to back, no stall (R1 R2 R3)
    both(16'h0000, 16'h0000);
    both(16'h0001, 16'h0001);
    both(16'hFFFF, 16'hFFFF);
    both(16'h8000, 16'h8000);
    both(16'h7FFF, 16'h8000);
    both(16'h7FFF, 16'h7FFF);
    both(16'h5555, 16'hAAAA);
    both(16'hAAAA, 16'hAAAA);
    both(16'h0007, 16'hFFFD);
    both(16'h1234, 16'h0000);
    both(16'h0002, 16'hC000);
    idle(4);

    // R8: bubbles between pairs
    for (int i = 0; i < 40; i++) begin
      send(16'($urandom), 16'($urandom), 1'($urandom));
      idle(1 + ($urandom % 3));
    end

    // R5 R6: random back-pressure with mixed small/large operands
    stall_pct = 40;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom % 2) b = 16'($signed(b[5:0]));
      send(a, b, 1'($urandom));
      if (($urandom % 5) == 0) idle(1 + ($urandom % 2));
    end
    idle(2);
    stall_pct = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(q_exp.size() == 0, "R8 all products delivered", 32'(q_exp.size()), 32'd0);
    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=done", wd);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule